// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block decides whether an I2C slave takes part in the transfer that follows a START condition. A shift stage outside the block hands over each completed received byte. The byte comes with a strobe and a flag that marks the first byte after START. The recognizer compares these bytes against a programmed own address. It then raises an "addressed" flag, a "general call" flag and the read/write direction taken from the first byte.

Two mode inputs select the behaviour:

- `free_fmt_i` turns off address recognition. In that mode every transfer is taken as plain data and the slave is always selected.
- `ten_bit_i` chooses the address format. In 7-bit form only the upper seven bits of the 10-bit own-address input are compared. In 10-bit form the whole register is compared, across two bytes.

A START clears all results before the new address phase begins.

The core is a four-state machine:

- **ST_WAIT_FIRST**: waits for the first byte after START.
- **ST_WAIT_SECOND**: the 10-bit prefix has matched and the low byte is still pending.
- **ST_SELECTED**: the slave is addressed.
- **ST_REJECTED**: the address did not match. The machine stays here until the next START.

A fifth state, **ST_FREE**, holds the free-data selection.

The transitions are:

- **T_START**: any state goes to ST_WAIT_FIRST.
- **T_GCALL**: ST_WAIT_FIRST goes to ST_SELECTED on byte 0x00.
- **T_HIT7**: ST_WAIT_FIRST goes to ST_SELECTED on a 7-bit match.
- **T_PFX_OK**: ST_WAIT_FIRST goes to ST_WAIT_SECOND.
- **T_LO_OK**: ST_WAIT_SECOND goes to ST_SELECTED.
- **T_MISS**: any compare that fails goes to ST_REJECTED.
- **T_FREE**: ST_WAIT_FIRST goes to ST_FREE in free-data mode.

All outputs are registered. They change on the clock edge that samples the byte or the START.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `addressed_o`, `gcall_o` and `dir_rd_o` are all 0.
- R2: In addressing mode with 7-bit format, a first byte whose bits [7:1] equal `own_addr_i[9:3]` sets `addressed_o` one cycle later. In the same cycle, `dir_rd_o` takes byte bit 0 (1 = read). `own_addr_i[2:0]` has no effect on this compare.
- R3: A first byte that fails the compare leaves `addressed_o` at 0. Later bytes before the next START cannot set it.
- R4: In addressing mode, a first byte of 0x00 is a general call in either format. It sets `addressed_o` and `gcall_o` and leaves `dir_rd_o` at 0.
- R5: In 10-bit format, the first byte must equal {11110, `own_addr_i[9:8]`, rw}. This byte alone does not set `addressed_o`. A following non-first byte equal to `own_addr_i[7:0]` then sets `addressed_o`, and `dir_rd_o` takes the rw bit of the first byte.
- R6: In 10-bit format, a mismatch in either the first or the second byte leaves `addressed_o` at 0.
- R7: In free-data mode (`free_fmt_i`=1), the first byte after START sets `addressed_o` whatever its value. `gcall_o` and `dir_rd_o` stay 0, even for byte 0x00.
- R8: A START clears `addressed_o`, `gcall_o` and `dir_rd_o` one cycle later.
- R9: When `start_i` and `byte_vld_i` are high in the same cycle, the START wins and the byte is discarded.
- R10: While waiting for the first byte, a byte with `byte_first_i`=0 is ignored. The recognizer keeps waiting and does not reject.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr_i | input | 10 | Programmed own slave address |
| free_fmt_i | input | 1 | 1 = free-data format, no recognition |
| ten_bit_i | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| start_i | input | 1 | One-cycle strobe for a detected START |
| byte_vld_i | input | 1 | One-cycle strobe for a completed received byte |
| byte_first_i | input | 1 | Marks the byte as the first after START |
| byte_i | input | 8 | Received byte value |
| addressed_o | output | 1 | Slave is selected for this transfer |
| gcall_o | output | 1 | General call recognised |
| dir_rd_o | output | 1 | Captured direction, 1 = master reads |

## Verification
The one same-cycle collision this block has is a START strobe arriving together with a completed byte. The bench provokes it twice: once while the slave is already selected, and once with a matching address byte in the colliding cycle. It judges the result by whether all three flags read 0 afterwards. It then checks that the recognizer still waits for a fresh first byte: a following non-first byte must change nothing, and a later matching first byte must select again.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_FIRST  = 3'd0,
        ST_WAIT_SECOND = 3'd1,
        ST_SELECTED    = 3'd2,
        ST_REJECTED    = 3'd3,
        ST_FREE        = 3'd4
    } am_state_e;

    typedef struct packed {
        logic gcall;
        logic hit7;
        logic pfx10;
        logic lo10;
    } am_hits_t;

endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic [ADDR_W-1:0]  own_addr_i,
    input  logic [BYTE_W-1:0]  byte_i,
    output i2c_am_pkg::am_hits_t hits_o
);
    localparam int SHORT_W = BYTE_W - 1;
    localparam int HI_W    = ADDR_W - BYTE_W;
    localparam int PFX_W   = BYTE_W - 1 - HI_W;
    localparam logic [PFX_W-1:0] PFX_VAL = {{(PFX_W-1){1'b1}}, 1'b0};

    logic [SHORT_W-1:0] addr_bits;
    logic [SHORT_W-1:0] own_short;
    logic [SHORT_W-1:0] own_long_hdr;

    always_comb begin
        addr_bits    = byte_i[BYTE_W-1:1];
        own_short    = own_addr_i[ADDR_W-1 -: SHORT_W];
        own_long_hdr = {PFX_VAL, own_addr_i[ADDR_W-1 -: HI_W]};

        hits_o.gcall = (byte_i == '0);
        hits_o.hit7  = (addr_bits == own_short);
        hits_o.pfx10 = (addr_bits == own_long_hdr);
        hits_o.lo10  = (byte_i == own_addr_i[BYTE_W-1:0]);
    end
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 free_fmt_i,
    input  logic                 ten_bit_i,
    input  logic                 start_i,
    input  logic                 byte_vld_i,
    input  logic                 byte_first_i,
    input  logic                 rw_bit_i,
    input  i2c_am_pkg::am_hits_t hits_i,
    output logic                 addressed_o,
    output logic                 gcall_o,
    output logic                 dir_rd_o
);
    import i2c_am_pkg::*;

    am_state_e state_q, state_d;
    logic      rw_pend_q;
    logic      take_first;
    logic      take_second;
    logic      gc_event;

    always_comb begin
        take_first  = byte_vld_i && byte_first_i;
        take_second = byte_vld_i && !byte_first_i;
        gc_event    = 1'b0;
        state_d     = state_q;
        if (start_i) begin
            state_d = ST_WAIT_FIRST;                // T_START
        end else begin
            unique case (state_q)
                ST_WAIT_FIRST: begin
                    if (take_first) begin
                        if (free_fmt_i) begin
                            state_d = ST_FREE;      // T_FREE
                        end else if (hits_i.gcall) begin
                            state_d  = ST_SELECTED; // T_GCALL
                            gc_event = 1'b1;
                        end else if (ten_bit_i) begin
                            state_d = hits_i.pfx10 ? ST_WAIT_SECOND : ST_REJECTED;
                        end else begin
                            state_d = hits_i.hit7 ? ST_SELECTED : ST_REJECTED;
                        end
                    end
                end
                ST_WAIT_SECOND: begin
                    if (take_second) begin
                        state_d = hits_i.lo10 ? ST_SELECTED : ST_REJECTED;
                    end else if (take_first) begin
                        state_d = ST_REJECTED;
                    end
                end
                ST_SELECTED: state_d = ST_SELECTED;
                ST_REJECTED: state_d = ST_REJECTED;
                ST_FREE:     state_d = ST_FREE;
                default:     state_d = ST_WAIT_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addressed_o <= 1'b0;
            gcall_o     <= 1'b0;
            dir_rd_o    <= 1'b0;
            rw_pend_q   <= 1'b0;
        end else if (start_i) begin
            addressed_o <= 1'b0;
            gcall_o     <= 1'b0;
            dir_rd_o    <= 1'b0;
            rw_pend_q   <= 1'b0;
        end else begin
            addressed_o <= (state_d == ST_SELECTED) || (state_d == ST_FREE);
            if (state_q == ST_WAIT_FIRST && state_d == ST_WAIT_SECOND) begin
                rw_pend_q <= rw_bit_i;
            end
            if (state_q != ST_SELECTED && state_d == ST_SELECTED) begin
                gcall_o  <= gc_event;
                dir_rd_o <= (state_q == ST_WAIT_SECOND) ? rw_pend_q : rw_bit_i;
            end
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              free_fmt_i,
    input  logic              ten_bit_i,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic              byte_first_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              addressed_o,
    output logic              gcall_o,
    output logic              dir_rd_o
);
    i2c_am_pkg::am_hits_t hits;

    i2c_am_cmp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_cmp (
        .own_addr_i (own_addr_i),
        .byte_i     (byte_i),
        .hits_o     (hits)
    );

    i2c_am_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .free_fmt_i   (free_fmt_i),
        .ten_bit_i    (ten_bit_i),
        .start_i      (start_i),
        .byte_vld_i   (byte_vld_i),
        .byte_first_i (byte_first_i),
        .rw_bit_i     (byte_i[0]),
        .hits_i       (hits),
        .addressed_o  (addressed_o),
        .gcall_o      (gcall_o),
        .dir_rd_o     (dir_rd_o)
    );
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic clk,
    input logic rst_n,
    input logic free_fmt_i,
    input logic ten_bit_i,
    input logic start_i,
    input logic byte_vld_i,
    input logic byte_first_i,
    input logic addressed_o,
    input logic gcall_o,
    input logic dir_rd_o
);
    assert_gcall_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gcall_o |-> addressed_o);

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!addressed_o && !gcall_o && !dir_rd_o));

    assert_rise_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addressed_o) |-> $past(byte_vld_i && !start_i));

    assert_hold_without_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !byte_vld_i) |=> ($stable(addressed_o) && $stable(gcall_o) && $stable(dir_rd_o)));

    assert_free_no_gcall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gcall_o) |-> !$past(free_fmt_i));

    assert_ten_second_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addressed_o) && !gcall_o && $past(ten_bit_i) && !$past(free_fmt_i))
        |-> !$past(byte_first_i));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .free_fmt_i   (free_fmt_i),
    .ten_bit_i    (ten_bit_i),
    .start_i      (start_i),
    .byte_vld_i   (byte_vld_i),
    .byte_first_i (byte_first_i),
    .addressed_o  (addressed_o),
    .gcall_o      (gcall_o),
    .dir_rd_o     (dir_rd_o)
);

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
    localparam logic [9:0] OWN = 10'b10_1100_1110; // 7-bit hdr 0xB2, 10-bit hdr 0xF4, low 0xCE

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] own_addr_i = OWN;
    logic       free_fmt_i = 1'b0;
    logic       ten_bit_i = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic       byte_first_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       addressed_o, gcall_o, dir_rd_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  a;
        logic  g;
        logic  d;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    i2c_addr_match dut (
        .clk(clk), .rst_n(rst_n), .own_addr_i(own_addr_i),
        .free_fmt_i(free_fmt_i), .ten_bit_i(ten_bit_i),
        .start_i(start_i), .byte_vld_i(byte_vld_i),
        .byte_first_i(byte_first_i), .byte_i(byte_i),
        .addressed_o(addressed_o), .gcall_o(gcall_o), .dir_rd_o(dir_rd_o)
    );

    // Monitor: compares queued expectations after each falling edge.
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (addressed_o !== e.a || gcall_o !== e.g || dir_rd_o !== e.d) begin
                fails++;
                $display("FAIL %s: actual a=%b g=%b d=%b expected a=%b g=%b d=%b",
                         e.tag, addressed_o, gcall_o, dir_rd_o, e.a, e.g, e.d);
            end
        end
    end

    // Driver: one cycle of stimulus, then push the expected result.
    task automatic step(input logic s, input logic v, input logic f, input logic [7:0] b,
                        input logic ea, input logic eg, input logic ed, input string tag);
        start_i = s; byte_vld_i = v; byte_first_i = f; byte_i = b;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0; byte_first_i = 1'b0;
        sb_q.push_back('{ea, eg, ed, tag});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sb_q.push_back('{1'b0, 1'b0, 1'b0, "R1 reset"});
        @(negedge clk);

        // 7-bit match, read
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'hB3, 1, 0, 1, "R2 7bit match rd");
        step(0, 1, 0, 8'h55, 1, 0, 1, "R2 data keeps select");
        // low own bits are don't care
        own_addr_i = OWN ^ 10'b111;
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start clears");
        step(0, 1, 1, 8'hB2, 1, 0, 0, "R2 low bits ignored wr");
        own_addr_i = OWN;
        // mismatch
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'hB4, 0, 0, 0, "R3 mismatch");
        step(0, 1, 0, 8'hB2, 0, 0, 0, "R3 later byte no effect");
        step(0, 1, 1, 8'hB2, 0, 0, 0, "R3 later first byte no effect");
        // general call
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'h00, 1, 1, 0, "R4 general call 7bit");
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start clears gcall");
        // R10 non-first ignored while waiting
        step(0, 1, 0, 8'hB3, 0, 0, 0, "R10 non-first ignored");
        step(0, 1, 1, 8'hB3, 1, 0, 1, "R10 still waiting");
        // R9 collision while selected
        step(1, 1, 1, 8'hB3, 0, 0, 0, "R9 start beats byte");
        step(0, 1, 0, 8'hCE, 0, 0, 0, "R9 byte discarded");
        step(0, 1, 1, 8'hB2, 1, 0, 0, "R9 waits for fresh first");
        // 10-bit
        ten_bit_i = 1'b1;
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'hF5, 0, 0, 0, "R5 prefix alone");
        step(0, 1, 0, 8'hCE, 1, 0, 1, "R5 10bit match rd");
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'hF4, 0, 0, 0, "R5 prefix wr");
        step(0, 1, 0, 8'hCE, 1, 0, 0, "R5 10bit match wr");
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'hF4, 0, 0, 0, "R6 prefix ok");
        step(0, 1, 0, 8'hCF, 0, 0, 0, "R6 low mismatch");
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'hF6, 0, 0, 0, "R6 hi mismatch");
        step(0, 1, 0, 8'hCE, 0, 0, 0, "R6 low alone no match");
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'hB2, 0, 0, 0, "R6 7bit byte in 10bit");
        step(0, 1, 0, 8'hCE, 0, 0, 0, "R6 no match after 7bit byte");
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'h00, 1, 1, 0, "R4 general call 10bit");
        // R9 collision carrying a prefix
        step(1, 1, 1, 8'hF5, 0, 0, 0, "R9 start beats prefix");
        step(0, 1, 0, 8'hCE, 0, 0, 0, "R9 prefix discarded");
        // free data
        free_fmt_i = 1'b1;
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'h37, 1, 0, 0, "R7 free any byte");
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'h00, 1, 0, 0, "R7 free zero no gcall");
        step(1, 0, 0, 8'h00, 0, 0, 0, "R8 start");
        step(0, 1, 1, 8'hB3, 1, 0, 0, "R7 free no dir");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule